// File: doc/BRIEF.md
# Receive/Transmit Done-Flag Controller

This block holds two completion flags, one for a receive path and one for a transmit path, both in the system clock domain. A flag rises when its path reports end of frame. It can be cleared in one of two ways, and a single mode input selects which. With auto-clear off, a dedicated clear input per path clears the flag. With auto-clear on, the flag clears itself a fixed number of cycles after the end-of-frame strobe, and the clear inputs are ignored.

The two channels are identical and share nothing except clock, reset and the mode input. The self-clear delay is a parameter whose default is two cycles. A new end-of-frame strobe always takes priority over a clear, so no completion is lost. A new strobe during a countdown starts the countdown again. Leaving auto-clear mode cancels any countdown in progress.

Top module: `done_flag_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, both done flags are 0 after that edge and any pending self-clear is dropped.
- R2: An end-of-frame input sampled high at a rising edge makes its done flag 1 after that edge.
- R3: With `auto_clear_en` = 0, a clear input sampled at 1 clears its flag at that edge. A clear input at 0 leaves the flag as it is.
- R4: With `auto_clear_en` = 1 held, a flag set at edge k reads 1 after edges k and k+1 and 0 after edge k+2 (DELAY = 2), unless a new strobe arrives first.
- R5: With `auto_clear_en` = 1, the clear inputs have no effect on either flag.
- R6: When end-of-frame and a clear meet at the same edge, the flag is 1 after that edge, in either mode.
- R7: In auto-clear mode, an end-of-frame strobe during a countdown restarts it, so the flag clears DELAY edges after the latest strobe.
- R8: If `auto_clear_en` is 0 at any edge after the strobe and before the countdown expires, the self-clear is cancelled and the flag stays set.
- R9: Receive and transmit inputs affect only their own flag.
- R10: With no strobe, no effective clear and no expiring countdown, a flag keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| auto_clear_en | input | 1 | 1 selects self-clear, 0 selects clear inputs |
| rx_eof | input | 1 | Receive end-of-frame strobe |
| rx_clr | input | 1 | Receive manual clear, 1 clears |
| tx_eof | input | 1 | Transmit end-of-frame strobe |
| tx_clr | input | 1 | Transmit manual clear, 1 clears |
| rx_done | output | 1 | Receive done flag |
| tx_done | output | 1 | Transmit done flag |

## Verification
Sets, manual clears and resets show on the flag right after the edge that samples them, because the flag is the only register on that path. The self-clear shows DELAY edges after the strobe edge. The bench drives inputs on the falling edge. It updates its own model at the rising edge and compares at the next falling edge, so every result is read one half-period after the edge that produced it. The model measures the age of the last strobe and whether auto mode has stayed on since then. It does not count down a register.

// File: rtl/donefl_pkg.sv
package donefl_pkg;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_RX  = 0;
  localparam int unsigned CH_TX  = 1;

  // Width of a counter that must hold values 0..d.
  function automatic int unsigned count_width(input int unsigned d);
    return (d < 2) ? 1 : $clog2(d + 1);
  endfunction

  // Next value of a self-clear countdown, in plain integer arithmetic.
  function automatic int unsigned countdown_next(
    input int unsigned cur,
    input int unsigned delay,
    input bit          strobe,
    input bit          auto_on
  );
    if (strobe)        return auto_on ? delay : 0;
    else if (!auto_on) return 0;
    else if (cur != 0) return cur - 1;
    else               return 0;
  endfunction

  // High when the countdown is on its last step at this edge.
  function automatic bit countdown_expires(
    input int unsigned cur,
    input bit          strobe,
    input bit          auto_on
  );
    return auto_on && !strobe && (cur == 1);
  endfunction

endpackage

// File: rtl/donefl_countdown.sv
module donefl_countdown #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_on,
  input  logic strobe,
  output logic expire
);
  import donefl_pkg::*;

  localparam int unsigned CW = count_width(DELAY);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d  = CW'(countdown_next(int'(cnt_q), DELAY, strobe, auto_on));
    expire = countdown_expires(int'(cnt_q), strobe, auto_on);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

endmodule

// File: rtl/donefl_flag.sv
module donefl_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);
  // Set takes priority over any clear source.
  always_ff @(posedge clk) begin
    if (rst)          flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end
endmodule

// File: rtl/done_flag_ctrl.sv
module done_flag_ctrl #(
  parameter int unsigned DELAY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic auto_clear_en,
  input  logic rx_eof,
  input  logic rx_clr,
  input  logic tx_eof,
  input  logic tx_clr,
  output logic rx_done,
  output logic tx_done
);
  import donefl_pkg::*;

  logic [NUM_CH-1:0] eof_v;
  logic [NUM_CH-1:0] clr_v;
  logic [NUM_CH-1:0] done_v;

  // Named internal events, brought out for the checker.
  logic [NUM_CH-1:0] set_evt_v;
  logic [NUM_CH-1:0] man_clr_evt_v;
  logic [NUM_CH-1:0] auto_clr_evt_v;

  assign eof_v[CH_RX] = rx_eof;
  assign eof_v[CH_TX] = tx_eof;
  assign clr_v[CH_RX] = rx_clr;
  assign clr_v[CH_TX] = tx_clr;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign set_evt_v[c]     = eof_v[c];
    assign man_clr_evt_v[c] = clr_v[c] & ~auto_clear_en;

    donefl_countdown #(.DELAY(DELAY)) u_cd (
      .clk     (clk),
      .rst     (rst),
      .auto_on (auto_clear_en),
      .strobe  (eof_v[c]),
      .expire  (auto_clr_evt_v[c])
    );

    donefl_flag u_flag (
      .clk     (clk),
      .rst     (rst),
      .set_evt (set_evt_v[c]),
      .clr_evt (man_clr_evt_v[c] | auto_clr_evt_v[c]),
      .flag    (done_v[c])
    );
  end

  assign rx_done = done_v[CH_RX];
  assign tx_done = done_v[CH_TX];

endmodule

// File: rtl/done_flag_ctrl_sva.sv
module done_flag_ctrl_sva (
  input logic       clk,
  input logic       rst,
  input logic       auto_clear_en,
  input logic       rx_eof,
  input logic       rx_clr,
  input logic       tx_eof,
  input logic       tx_clr,
  input logic       rx_done,
  input logic       tx_done,
  input logic [1:0] auto_clr_evt_v
);
  logic [1:0] eof;
  logic [1:0] clr;
  logic [1:0] done;
  assign eof  = {tx_eof, rx_eof};
  assign clr  = {tx_clr, rx_clr};
  assign done = {tx_done, rx_done};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!rx_done && !tx_done));

  for (genvar c = 0; c < 2; c++) begin : g_chk
    a_r2_eof_sets: assert property (@(posedge clk) disable iff (rst)
      eof[c] |=> done[c]);
    a_r3_manual_clear: assert property (@(posedge clk) disable iff (rst)
      (!auto_clear_en && clr[c] && !eof[c]) |=> !done[c]);
    a_r4_auto_expiry_clears: assert property (@(posedge clk) disable iff (rst)
      auto_clr_evt_v[c] |=> !done[c]);
    a_r5_clear_ignored_in_auto: assert property (@(posedge clk) disable iff (rst)
      (auto_clear_en && clr[c] && !eof[c] && !auto_clr_evt_v[c]) |=>
        (done[c] == $past(done[c])));
    a_r8_no_expiry_outside_auto: assert property (@(posedge clk) disable iff (rst)
      !auto_clear_en |-> !auto_clr_evt_v[c]);
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
      (!eof[c] && !clr[c] && !auto_clr_evt_v[c]) |=> $stable(done[c]));
  end

endmodule

bind done_flag_ctrl done_flag_ctrl_sva u_sva (
  .clk            (clk),
  .rst            (rst),
  .auto_clear_en  (auto_clear_en),
  .rx_eof         (rx_eof),
  .rx_clr         (rx_clr),
  .tx_eof         (tx_eof),
  .tx_clr         (tx_clr),
  .rx_done        (rx_done),
  .tx_done        (tx_done),
  .auto_clr_evt_v (auto_clr_evt_v)
);

// File: tb/test_done_flag_ctrl.sv
`timescale 1ns/1ps
module test_done_flag_ctrl;
  localparam int DLY = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_clear_en = 1'b0;
  logic rx_eof = 1'b0, rx_clr = 1'b0, tx_eof = 1'b0, tx_clr = 1'b0;
  logic rx_done, tx_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // Reference state: flag, age of last strobe in edges, auto held since strobe.
  bit m_flag [2];
  int m_age  [2];
  bit m_arm  [2];

  always #5 clk = ~clk;

  done_flag_ctrl #(.DELAY(DLY)) i_done_flag_ctrl (
    .clk(clk), .rst(rst), .auto_clear_en(auto_clear_en),
    .rx_eof(rx_eof), .rx_clr(rx_clr), .tx_eof(tx_eof), .tx_clr(tx_clr),
    .rx_done(rx_done), .tx_done(tx_done)
  );

  task automatic check(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string pick_tag(bit r, bit a, bit e, bit c, int ch);
    if (r)      return "R1";
    if (e && c) return "R6";
    if (e)      return "R2";
    if (a && c) return "R5";
    if (!a && c) return "R3";
    if (a && m_arm[ch] && m_age[ch] + 1 == DLY) return "R4";
    if (!a && m_arm[ch]) return "R8";
    return "R10";
  endfunction

  function automatic void model_edge(bit r, bit a, bit e, bit c, int ch);
    if (r) begin
      m_flag[ch] = 0; m_arm[ch] = 0; m_age[ch] = 0;
    end else if (e) begin
      m_flag[ch] = 1; m_age[ch] = 0; m_arm[ch] = a;
    end else begin
      m_age[ch] = m_age[ch] + 1;
      if (!a) m_arm[ch] = 0;
      if (!a && c) m_flag[ch] = 0;
      if (m_arm[ch] && m_age[ch] == DLY) begin
        m_flag[ch] = 0; m_arm[ch] = 0;
      end
    end
  endfunction

  // Called at a falling edge: drive, take the rising edge, compare at next fall.
  task automatic cyc(input bit r, input bit a, input bit re, input bit rc,
                     input bit te, input bit tc, input string forced_tag);
    string t0, t1;
    rst = r; auto_clear_en = a; rx_eof = re; rx_clr = rc; tx_eof = te; tx_clr = tc;
    t0 = (forced_tag != "") ? forced_tag : pick_tag(r, a, re, rc, 0);
    t1 = (forced_tag != "") ? forced_tag : pick_tag(r, a, te, tc, 1);
    @(posedge clk);
    model_edge(r, a, re, rc, 0);
    model_edge(r, a, te, tc, 1);
    @(negedge clk);
    check(t0, "rx_done", rx_done, m_flag[0]);
    check(t1, "tx_done", tx_done, m_flag[1]);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    @(negedge clk);
    cyc(1, 0, 0, 0, 0, 0, "R1");
    cyc(1, 1, 1, 0, 1, 0, "R1");
    cyc(0, 0, 0, 0, 0, 0, "R10");

    // Manual mode: set, hold, clear; channels independent (R9).
    cyc(0, 0, 1, 0, 0, 0, "R2");
    check("R9", "tx untouched by rx eof", tx_done, 1'b0);
    cyc(0, 0, 0, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 0, 1, "R9");
    check("R9", "rx kept when tx cleared", rx_done, 1'b1);
    cyc(0, 0, 0, 1, 0, 0, "R3");
    cyc(0, 0, 1, 1, 1, 1, "R6");
    cyc(0, 0, 0, 1, 0, 1, "R3");

    // Auto mode timing: set at edge k, high after k, k+1, low after k+2.
    cyc(0, 1, 1, 0, 0, 0, "R4");
    check("R4", "high after strobe edge", rx_done, 1'b1);
    cyc(0, 1, 0, 1, 0, 0, "R5");
    check("R4", "high after edge k+1", rx_done, 1'b1);
    cyc(0, 1, 0, 0, 0, 0, "R4");
    check("R4", "low after edge k+2", rx_done, 1'b0);

    // Restart (R7).
    cyc(0, 1, 0, 0, 1, 0, "R7");
    cyc(0, 1, 0, 0, 1, 0, "R7");
    cyc(0, 1, 0, 0, 0, 0, "R7");
    check("R7", "still high one edge after restart", tx_done, 1'b1);
    cyc(0, 1, 0, 0, 0, 0, "R7");
    check("R7", "low two edges after latest strobe", tx_done, 1'b0);

    // Cancel by leaving auto mode (R8).
    cyc(0, 1, 1, 0, 0, 0, "R8");
    cyc(0, 0, 0, 0, 0, 0, "R8");
    cyc(0, 1, 0, 0, 0, 0, "R8");
    cyc(0, 1, 0, 0, 0, 0, "R8");
    check("R8", "flag survives cancelled countdown", rx_done, 1'b1);
    cyc(0, 1, 0, 1, 0, 1, "R5");
    check("R5", "clear ignored in auto", rx_done, 1'b1);
    cyc(0, 1, 1, 1, 0, 0, "R6");

    // Reset drops a pending countdown.
    cyc(1, 1, 0, 0, 0, 0, "R1");
    cyc(0, 1, 0, 0, 0, 0, "R1");

    // Near-exhaustive pseudo-random sweep over all input combinations.
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      bit r, a, re, rc, te, tc;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r  = (lfsr[7:0] == 8'h5A);
      a  = (i % 400) < 260 ? 1'b1 : lfsr[11];
      re = (lfsr[2:0] == 3'd0);
      rc = lfsr[4] & lfsr[5];
      te = (lfsr[10:8] == 3'd3);
      tc = lfsr[13] & lfsr[14];
      cyc(r, a, re, rc, te, tc, "");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule